// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block gathers every interrupt cause that arises inside a UART and turns them into one active-high interrupt line and a six-bit status code. The code always names exactly one cause: the most urgent pending one. Less urgent causes stay latched behind it. They appear in turn once the reported cause has been serviced.

The serial engine, the FIFOs and the modem pins are outside this block. They reach it as level vectors, event pulses and single-cycle register-access strobes. Each cause has its own way of clearing. Depending on the cause, this is a register access, a FIFO level falling, or a later received character. A receive character-timeout counter is built into the block. It counts bit-time ticks supplied from outside.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the status code is 6'h01 (nothing pending) and `irq` is low.
- R2: Status codes are LINE=6'h06, RXTO=6'h0C, RXDAT=6'h04, TXRDY=6'h02, MODEM=6'h00, CHAR=6'h10, FLOW=6'h20, WAKE=6'h30 and none=6'h01. Priority runs in that order, with LINE the highest. Only the highest enabled pending cause is reported.
- R3: A pulse on any bit of `line_err` latches the line cause. `rd_lsr` clears it. When a new error and `rd_lsr` arrive in the same cycle, the cause stays set.
- R4: The receive-data cause is present while `rx_level >= rx_trig`. It goes away as soon as the level falls below the trigger.
- R5: While `rx_level` is non-zero, the timeout cause sets after 4*CHAR_BITS+12 `bit_tick` pulses with no `rx_char` and no `rd_rhr`. It does not set after one tick fewer. `rd_rhr` clears it.
- R6: The transmit cause sets when `tx_level` drops to or below `tx_trig`, or when the transmit FIFO becomes empty. `wr_thr` clears it. A status read clears it while it is the reported cause.
- R7: A pulse on any bit of `msr_chg` latches the modem cause. `rd_msr` clears it.
- R8: `xoff_hit` latches the CHAR cause, and `xon_hit` clears that part. `spec_hit` also latches the CHAR cause, and the next `rx_char` clears that part. A status read clears both parts while CHAR is reported.
- R9: A rising edge on `cts_in` sets the FLOW cause only when both `cts_ien` and `ext_mode` are 1. `flow_evt` also sets FLOW. `rd_msr` clears it.
- R10: `wake_evt` latches the WAKE cause. A status read clears it while it is the reported cause.
- R11: A status read clears only the cause it reports. Causes below it stay pending.
- R12: `ien[i]` (bit index = priority rank, 0 = LINE) hides a cause from the code and `irq` without discarding its latch. `irq` is high exactly when code bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 8 | Per-cause enable, index = priority rank |
| cts_ien | input | 1 | Enable for the CTS-edge cause |
| ext_mode | input | 1 | Extended mode; qualifies `cts_ien` |
| line_err | input | 4 | Line error event pulses |
| msr_chg | input | 4 | Modem-status change pulses |
| rx_level | input | FIFO_AW+1 | Receive FIFO fill level |
| rx_trig | input | FIFO_AW+1 | Receive trigger level |
| tx_level | input | FIFO_AW+1 | Transmit FIFO fill level |
| tx_trig | input | FIFO_AW+1 | Transmit trigger level |
| rx_char | input | 1 | Character received pulse |
| bit_tick | input | 1 | One pulse per bit time |
| xoff_hit | input | 1 | Xoff character detected |
| xon_hit | input | 1 | Xon character detected |
| spec_hit | input | 1 | Special character detected |
| flow_evt | input | 1 | Automatic flow-control deassertion |
| cts_in | input | 1 | CTS pin level |
| wake_evt | input | 1 | Wake-up from sleep |
| rd_isr | input | 1 | Status register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| rd_rhr | input | 1 | Receive holding register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request, active high |
| isr_code | output | 6 | Code of highest pending cause |

## Verification
The clear-side properties assume that strobes and event pulses last one cycle. The line and modem clear checks also assume that no new event of the same kind lands in the cycle of the clearing read. The properties claim nothing about cycles where both happen.

The stimulus drives every pulse for exactly one clock. It raises a set and its clear together only in the one directed case that tests set-wins behaviour. It holds the FIFO levels steady except where a test moves them on purpose, so each expected code follows from the latched causes alone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC = 8;

   typedef enum logic [2:0] {
      SRC_LINE  = 3'd0,
      SRC_RXTO  = 3'd1,
      SRC_RXDAT = 3'd2,
      SRC_TXRDY = 3'd3,
      SRC_MODEM = 3'd4,
      SRC_CHAR  = 3'd5,
      SRC_FLOW  = 3'd6,
      SRC_WAKE  = 3'd7
   } src_e;

   localparam logic [5:0] CODE_NONE = 6'h01;

   function automatic logic [5:0] src_code(input int idx);
      case (idx)
         0:       return 6'h06;
         1:       return 6'h0C;
         2:       return 6'h04;
         3:       return 6'h02;
         4:       return 6'h00;
         5:       return 6'h10;
         6:       return 6'h20;
         default: return 6'h30;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
   parameter int LW        = 5,
   parameter int CHAR_BITS = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rx_level,
   input  logic          rx_char,
   input  logic          rd_rhr,
   input  logic          bit_tick,
   output logic          to_pend
);
   localparam int LIMIT = 4 * CHAR_BITS + 12;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;
   logic          restart, hit;

   assign restart = rx_char | rd_rhr | (rx_level == '0);
   assign hit     = (cnt == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (bit_tick && !hit) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_pend <= 1'b0;
      end else if (rd_rhr) begin
         to_pend <= 1'b0;
      end else if (hit) begin
         to_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs
   import uart_irq_pkg::*;
#(
   parameter int LW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] top_sel,
   input  logic            cts_ien,
   input  logic            ext_mode,
   input  logic [3:0]      line_err,
   input  logic [3:0]      msr_chg,
   input  logic [LW-1:0]   tx_level,
   input  logic [LW-1:0]   tx_trig,
   input  logic            rx_char,
   input  logic            xoff_hit,
   input  logic            xon_hit,
   input  logic            spec_hit,
   input  logic            flow_evt,
   input  logic            cts_in,
   input  logic            wake_evt,
   input  logic            rd_isr,
   input  logic            rd_lsr,
   input  logic            rd_msr,
   input  logic            wr_thr,
   output logic            line_p,
   output logic            tx_p,
   output logic            modem_p,
   output logic            char_p,
   output logic            flow_p,
   output logic            wake_p
);
   logic tx_low, tx_empty, tx_low_q, tx_empty_q, cts_q;
   logic xoff_p, spec_p;
   logic tx_set, cts_set;
   logic isr_tx, isr_char, isr_wake;

   assign tx_low   = (tx_level <= tx_trig);
   assign tx_empty = (tx_level == '0);
   assign tx_set   = (tx_low & ~tx_low_q) | (tx_empty & ~tx_empty_q);
   assign cts_set  = cts_in & ~cts_q & cts_ien & ext_mode;

   assign isr_tx   = rd_isr & top_sel[SRC_TXRDY];
   assign isr_char = rd_isr & top_sel[SRC_CHAR];
   assign isr_wake = rd_isr & top_sel[SRC_WAKE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_low_q   <= 1'b1;
         tx_empty_q <= 1'b1;
         cts_q      <= 1'b0;
      end else begin
         tx_low_q   <= tx_low;
         tx_empty_q <= tx_empty;
         cts_q      <= cts_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_p  <= 1'b0;
         tx_p    <= 1'b0;
         modem_p <= 1'b0;
         xoff_p  <= 1'b0;
         spec_p  <= 1'b0;
         flow_p  <= 1'b0;
         wake_p  <= 1'b0;
      end else begin
         line_p  <= (line_p  & ~rd_lsr)                 | (|line_err);
         tx_p    <= (tx_p    & ~(wr_thr | isr_tx))      | tx_set;
         modem_p <= (modem_p & ~rd_msr)                 | (|msr_chg);
         xoff_p  <= (xoff_p  & ~(xon_hit | isr_char))   | xoff_hit;
         spec_p  <= (spec_p  & ~(rx_char | isr_char))   | spec_hit;
         flow_p  <= (flow_p  & ~rd_msr)                 | flow_evt | cts_set;
         wake_p  <= (wake_p  & ~isr_wake)               | wake_evt;
      end
   end

   assign char_p = xoff_p | spec_p;
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
   import uart_irq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] pend,
   output logic [N-1:0] top_sel,
   output logic         irq,
   output logic [5:0]   code
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign blocked[i+1] = blocked[i] | pend[i];
      assign top_sel[i]   = pend[i] & ~blocked[i];
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < N; i++) begin
         if (top_sel[i]) code = code | src_code(i);
      end
      if (!blocked[N]) code = CODE_NONE;
   end

   assign irq = blocked[N];
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int FIFO_AW   = 4,
   parameter int CHAR_BITS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC-1:0]    ien,
   input  logic               cts_ien,
   input  logic               ext_mode,
   input  logic [3:0]         line_err,
   input  logic [3:0]         msr_chg,
   input  logic [FIFO_AW:0]   rx_level,
   input  logic [FIFO_AW:0]   rx_trig,
   input  logic [FIFO_AW:0]   tx_level,
   input  logic [FIFO_AW:0]   tx_trig,
   input  logic               rx_char,
   input  logic               bit_tick,
   input  logic               xoff_hit,
   input  logic               xon_hit,
   input  logic               spec_hit,
   input  logic               flow_evt,
   input  logic               cts_in,
   input  logic               wake_evt,
   input  logic               rd_isr,
   input  logic               rd_lsr,
   input  logic               rd_msr,
   input  logic               rd_rhr,
   input  logic               wr_thr,
   output logic               irq,
   output logic [5:0]         isr_code
);
   localparam int LW = FIFO_AW + 1;

   if (FIFO_AW < 1 || FIFO_AW > 10) begin : g_bad_aw
      $error("FIFO_AW out of range");
   end
   if (CHAR_BITS < 5 || CHAR_BITS > 12) begin : g_bad_cb
      $error("CHAR_BITS out of range");
   end

   logic [NSRC-1:0] pend, pend_m, top_sel;
   logic line_p, to_p, tx_p, modem_p, char_p, flow_p, wake_p;

   uart_irq_rxto #(.LW(LW), .CHAR_BITS(CHAR_BITS)) u_rxto (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_char(rx_char),
      .rd_rhr(rd_rhr), .bit_tick(bit_tick), .to_pend(to_p)
   );

   uart_irq_srcs #(.LW(LW)) u_srcs (
      .clk(clk), .rst_n(rst_n), .top_sel(top_sel), .cts_ien(cts_ien),
      .ext_mode(ext_mode), .line_err(line_err), .msr_chg(msr_chg),
      .tx_level(tx_level), .tx_trig(tx_trig), .rx_char(rx_char),
      .xoff_hit(xoff_hit), .xon_hit(xon_hit), .spec_hit(spec_hit),
      .flow_evt(flow_evt), .cts_in(cts_in), .wake_evt(wake_evt),
      .rd_isr(rd_isr), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr),
      .line_p(line_p), .tx_p(tx_p), .modem_p(modem_p), .char_p(char_p),
      .flow_p(flow_p), .wake_p(wake_p)
   );

   always_comb begin
      pend            = '0;
      pend[SRC_LINE]  = line_p;
      pend[SRC_RXTO]  = to_p;
      pend[SRC_RXDAT] = (rx_level >= rx_trig);
      pend[SRC_TXRDY] = tx_p;
      pend[SRC_MODEM] = modem_p;
      pend[SRC_CHAR]  = char_p;
      pend[SRC_FLOW]  = flow_p;
      pend[SRC_WAKE]  = wake_p;
   end

   assign pend_m = pend & ien;

   uart_irq_arb #(.N(NSRC)) u_arb (
      .pend(pend_m), .top_sel(top_sel), .irq(irq), .code(isr_code)
   );
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
   parameter int LW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    ien,
   input logic [3:0]    line_err,
   input logic [3:0]    msr_chg,
   input logic [LW-1:0] rx_level,
   input logic [LW-1:0] rx_trig,
   input logic          wake_evt,
   input logic          rd_isr,
   input logic          rd_lsr,
   input logic          rd_msr,
   input logic          rd_rhr,
   input logic          irq,
   input logic [5:0]    isr_code
);
   assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr && !(|line_err)) |=> (isr_code != 6'h06));

   assert_rxdat_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_level >= rx_trig) && ien[2]) |-> irq);

   assert_rxto_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rhr |=> (isr_code != 6'h0C));

   assert_modem_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_msr && !(|msr_chg)) |=> (isr_code != 6'h00));

   assert_wake_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_isr && isr_code == 6'h30 && !wake_evt) |=> (isr_code != 6'h30));

   assert_irq_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !isr_code[0]);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.LW(FIFO_AW + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .ien(ien), .line_err(line_err),
   .msr_chg(msr_chg), .rx_level(rx_level), .rx_trig(rx_trig),
   .wake_evt(wake_evt), .rd_isr(rd_isr), .rd_lsr(rd_lsr),
   .rd_msr(rd_msr), .rd_rhr(rd_rhr), .irq(irq), .isr_code(isr_code)
);

// File: tb/uart_irq_prio_bench.sv
`timescale 1ns/1ps
module uart_irq_prio_bench;
   localparam int AW = 4;
   localparam int CB = 10;
   localparam int TO = 4 * CB + 12;
   localparam logic [5:0] C_NONE = 6'h01, C_LINE = 6'h06, C_RXTO = 6'h0C,
      C_RXDAT = 6'h04, C_TX = 6'h02, C_MODEM = 6'h00, C_CHAR = 6'h10,
      C_FLOW = 6'h20, C_WAKE = 6'h30;

   logic clk = 0, rst_n = 0;
   logic [7:0] ien = 8'hFF;
   logic cts_ien = 0, ext_mode = 0;
   logic [3:0] line_err = 0, msr_chg = 0;
   logic [AW:0] rx_level = 0, rx_trig = 4, tx_level = 8, tx_trig = 2;
   logic rx_char = 0, bit_tick = 0, xoff_hit = 0, xon_hit = 0, spec_hit = 0;
   logic flow_evt = 0, cts_in = 0, wake_evt = 0;
   logic rd_isr = 0, rd_lsr = 0, rd_msr = 0, rd_rhr = 0, wr_thr = 0;
   logic irq;
   logic [5:0] isr_code;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   uart_irq_prio #(.FIFO_AW(AW), .CHAR_BITS(CB)) u_uart_irq_prio (
      .clk(clk), .rst_n(rst_n), .ien(ien), .cts_ien(cts_ien),
      .ext_mode(ext_mode), .line_err(line_err), .msr_chg(msr_chg),
      .rx_level(rx_level), .rx_trig(rx_trig), .tx_level(tx_level),
      .tx_trig(tx_trig), .rx_char(rx_char), .bit_tick(bit_tick),
      .xoff_hit(xoff_hit), .xon_hit(xon_hit), .spec_hit(spec_hit),
      .flow_evt(flow_evt), .cts_in(cts_in), .wake_evt(wake_evt),
      .rd_isr(rd_isr), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rhr(rd_rhr),
      .wr_thr(wr_thr), .irq(irq), .isr_code(isr_code)
   );

   // vector: [14:6] events {rd_isr,rd_msr,rd_lsr,flow,wake,spec,xoff,msr,line}, [5:0] expected code
   localparam logic [14:0] VEC [10] = '{
      {9'h010, C_WAKE},   // R10
      {9'h020, C_FLOW},   // R9
      {9'h008, C_CHAR},   // R8
      {9'h002, C_MODEM},  // R7
      {9'h001, C_LINE},   // R3, R2
      {9'h040, C_MODEM},  // R3 clear
      {9'h100, C_MODEM},  // R11 status read leaves modem
      {9'h080, C_CHAR},   // R7, R9 clear
      {9'h100, C_WAKE},   // R8, R11
      {9'h100, C_NONE}    // R10
   };

   task automatic chk(input string req, input logic [5:0] exp);
      checks++;
      if (isr_code !== exp || irq !== !exp[0]) begin
         fails++;
         $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                  req, isr_code, irq, exp, !exp[0]);
      end
   endtask

   task automatic step;
      @(posedge clk); #1;
      line_err = 0; msr_chg = 0; rx_char = 0; bit_tick = 0; xoff_hit = 0;
      xon_hit = 0; spec_hit = 0; flow_evt = 0; wake_evt = 0; rd_isr = 0;
      rd_lsr = 0; rd_msr = 0; rd_rhr = 0; wr_thr = 0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset", C_NONE);
      rst_n = 1;
      step;
      chk("R1 after release", C_NONE);

      for (int i = 0; i < 10; i++) begin
         line_err[0] = VEC[i][6];  msr_chg[2] = VEC[i][7];
         xoff_hit = VEC[i][8];     spec_hit = VEC[i][9];
         wake_evt = VEC[i][10];    flow_evt = VEC[i][11];
         rd_lsr = VEC[i][12];      rd_msr = VEC[i][13];
         rd_isr = VEC[i][14];
         step;
         chk($sformatf("R2 vector %0d", i), VEC[i][5:0]);
      end

      rx_level = 4; #1; chk("R4 at trigger", C_RXDAT);
      rx_level = 3; #1; chk("R4 below trigger", C_NONE);

      rx_char = 1; step;
      bit_tick = 1; repeat (TO - 1) @(posedge clk);
      #1 bit_tick = 0; step;
      chk("R5 one tick short", C_NONE);
      bit_tick = 1; step; step;
      chk("R5 timeout", C_RXTO);
      rd_rhr = 1; rx_level = 2; step;
      chk("R5 cleared by rhr read", C_NONE);
      rx_level = 0;

      line_err = 4'b1000; rd_lsr = 1; step;
      chk("R3 set wins over clear", C_LINE);
      tx_level = 2; step;
      chk("R6 under line", C_LINE);
      rd_isr = 1; step;
      chk("R11 status read keeps line", C_LINE);
      rd_lsr = 1; step;
      chk("R11 tx kept", C_TX);
      wr_thr = 1; step;
      chk("R6 thr write clears", C_NONE);
      tx_level = 0; step;
      chk("R6 empty", C_TX);
      rd_isr = 1; step;
      chk("R6 status read clears", C_NONE);

      xoff_hit = 1; step; chk("R8 xoff", C_CHAR);
      xon_hit = 1; step;  chk("R8 xon clears", C_NONE);
      spec_hit = 1; step; chk("R8 special", C_CHAR);
      rx_char = 1; step;  chk("R8 next char clears", C_NONE);

      cts_ien = 1; cts_in = 1; step;
      chk("R9 cts without ext_mode", C_NONE);
      cts_in = 0; ext_mode = 1; step;
      cts_in = 1; step;
      chk("R9 cts rise", C_FLOW);
      rd_msr = 1; step;
      chk("R9 msr read clears", C_NONE);

      ien[7] = 0; wake_evt = 1; step;
      chk("R12 masked", C_NONE);
      ien[7] = 1; #1;
      chk("R12 unmasked keeps latch", C_WAKE);
      rd_isr = 1; step;
      chk("R10 cleared", C_NONE);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule